// File: doc/BRIEF.md
# Register-Programmed Byte SPI Master

This block is a small SPI master seen by software as two 32-bit words on a byte-addressed register bus. The word at offset 0x0 holds control and status and the word at offset 0x4 holds the data byte. Software first places the outgoing byte in the data word. It then writes the control word with the start bit set. The block sends that byte on its serial output, most significant bit first, and collects eight bits from its serial input at the same time. Once the exchange is over, the collected byte can be read back from the data word.

The serial clock comes from the reference clock through a 5-bit divider. Three chip-select lines follow control bits directly and are never driven by the shift logic. An internal loopback switch feeds the outgoing bit stream back into the receive path in place of the serial input. A single busy flag, read in bit 1 of the control word, tells software when the byte has finished.

Top module: `bspiMaster`

## Requirements
- R1: After reset the control word reads 0x0000_0015 (all three selects high, divider 0, loopback off, idle) and the data word reads 0.
- R2: A write to offset 0x0 with bit 1 set while idle starts one exchange. Bit 1 of the control word then reads 1 for exactly 16×(D+1) reference cycles counted from the write edge, and 0 afterwards.
- R3: The select outputs chipSel[0], chipSel[1] and chipSel[2] follow control bits 0, 2 and 4. They take the written values on every control write, even while busy.
- R4: sclk is low whenever no exchange is running. During an exchange it is a square wave with a period of 2×(D+1) reference cycles that starts low, where D is control bits 31:27. It has exactly 8 rising edges per exchange.
- R5: Mode 0, MSB first. mosi holds bit 7 of the loaded byte from the start, moves to the next lower bit only after a falling sclk edge, and the input is sampled on rising sclk edges.
- R6: With control bit 3 set, the received byte equals the transmitted byte and the miso pin has no effect.
- R7: After busy clears, the data word reads the eight bits sampled during the exchange, the first one sampled in bit 7.
- R8: While busy, a control write with bit 1 set does not restart or extend the exchange, and a data write does not change the bits being sent.
- R9: The control word reads the divider in bits 31:27, the selects in bits 0, 2 and 4, loopback in bit 3 and the live busy flag in bit 1. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Byte address: 0x0 control/status, 0x4 data |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| chipSel | output | 3 | Chip-select levels taken from control bits 0, 2, 4 |

## Verification
The hardest case to reach from the ports is a register write that arrives in the middle of an exchange. The register protocol says software should not issue one, so this case would otherwise never be exercised. The bench forces it with a control write that carries the start bit, and then a data write of a different byte, both at a fixed cycle inside a running exchange. The per-cycle reference model keeps predicting the original busy length, sclk waveform and mosi bit sequence, so any restart or reload shows up as a mismatch in that same cycle.

// File: rtl/bspi_pkg.sv
package bspi_pkg;
  // Strobes from the sequencer to the shift datapath.
  typedef struct packed {
    logic load;    // take a new byte from the bus
    logic sample;  // rising sclk: capture the input bit
    logic shift;   // falling sclk: advance the shift register
  } dpStrobe_t;

  localparam int CTL_START_BIT = 1;
  localparam int CTL_LOOP_BIT  = 3;
endpackage

// File: rtl/bspiData.sv
module bspiData
  import bspi_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] wrByte,
  input  logic              miso,
  input  logic              loopEn,
  output logic              mosi,
  output logic [WORD_W-1:0] rxByte
);
  logic [WORD_W-1:0] shReg;
  logic              sampBit;

  assign mosi   = shReg[WORD_W-1];
  assign rxByte = shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      sampBit <= 1'b0;
    end else begin
      if (strobe.load)
        shReg <= wrByte;
      else if (strobe.shift)
        shReg <= {shReg[WORD_W-2:0], sampBit};
      if (strobe.sample)
        sampBit <= loopEn ? shReg[WORD_W-1] : miso;
    end
  end

  // R7: a load places the written byte in the shift register
  p_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> shReg == $past(wrByte));
  // R5: the outgoing bit only moves on a load or a falling edge
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.shift) |=> $stable(shReg));
endmodule

// File: rtl/bspiCtrl.sv
module bspiCtrl
  import bspi_pkg::*;
#(
  parameter int DIV_W   = 5,
  parameter int BIT_CNT = 8,
  parameter int CS_N    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWr,
  input  logic             dataWr,
  input  logic [31:0]      wrData,
  output dpStrobe_t        strobe,
  output logic             sclk,
  output logic             busy,
  output logic             loopEn,
  output logic [CS_N-1:0]  csLevel,
  output logic [DIV_W-1:0] divVal
);
  localparam int DIV_LSB = 32 - DIV_W;
  localparam int CNT_W   = $clog2(BIT_CNT);

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             edgeNow;
  logic [CS_N-1:0]  csNext;

  always_comb begin
    for (int n = 0; n < CS_N; n++) csNext[n] = wrData[2*n];
  end

  assign edgeNow       = busy && (divCnt >= divVal);
  assign strobe.load   = dataWr && !busy;
  assign strobe.sample = edgeNow && !sclk;
  assign strobe.shift  = edgeNow && sclk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csLevel <= '1;
      loopEn  <= 1'b0;
      divVal  <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
      sclk    <= 1'b0;
      busy    <= 1'b0;
    end else begin
      if (ctlWr) begin
        csLevel <= csNext;
        loopEn  <= wrData[CTL_LOOP_BIT];
        divVal  <= wrData[31:DIV_LSB];
      end
      if (!busy) begin
        if (ctlWr && wrData[CTL_START_BIT]) begin
          busy   <= 1'b1;
          divCnt <= '0;
          bitCnt <= '0;
          sclk   <= 1'b0;
        end
      end else if (edgeNow) begin
        divCnt <= '0;
        sclk   <= ~sclk;
        if (sclk) begin
          if (bitCnt == CNT_W'(BIT_CNT - 1))
            busy <= 1'b0;
          else
            bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // R4: serial clock rests low when idle
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);
  // R2: a start command while idle raises busy
  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && wrData[CTL_START_BIT] && !busy) |=> busy);
  // R4: sclk only toggles when the half-period count is reached
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !edgeNow) |=> $stable(sclk));
  // R8: a start while busy does not rewind the bit count
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctlWr && !edgeNow) |=> bitCnt == $past(bitCnt));
  // R3: selects take the written control bits
  p_cs_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> csLevel == $past(csNext));
endmodule

// File: rtl/bspiMaster.sv
module bspiMaster
  import bspi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [2:0]        chipSel
);
  localparam int WORD_W = 8;
  localparam int PAD_W  = 32 - DIV_W - 5;

  dpStrobe_t         strobe;
  logic              busy, loopEn, ctlSel, dataSel;
  logic [DIV_W-1:0]  divVal;
  logic [WORD_W-1:0] rxByte;
  logic [31:0]       ctlWord;

  assign ctlSel  = (addr == ADDR_W'(0));
  assign dataSel = (addr == ADDR_W'(4));

  bspiCtrl #(.DIV_W(DIV_W), .BIT_CNT(WORD_W), .CS_N(3)) uCtrl (
    .clk(clk), .rstN(rstN),
    .ctlWr(wrEn && ctlSel), .dataWr(wrEn && dataSel), .wrData(wrData),
    .strobe(strobe), .sclk(sclk), .busy(busy), .loopEn(loopEn),
    .csLevel(chipSel), .divVal(divVal)
  );

  bspiData #(.WORD_W(WORD_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrByte(wrData[WORD_W-1:0]),
    .miso(miso), .loopEn(loopEn), .mosi(mosi), .rxByte(rxByte)
  );

  assign ctlWord = {divVal, {PAD_W{1'b0}}, chipSel[2], loopEn, chipSel[1],
                    busy, chipSel[0]};

  always_comb begin
    if (ctlSel)       rdData = ctlWord;
    else if (dataSel) rdData = {{(32-WORD_W){1'b0}}, rxByte};
    else              rdData = '0;
  end
endmodule

// File: tb/tb_bspiMaster.sv
module tb_bspiMaster;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rstN = 0, wrEn = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wrData = 0;
  logic [31:0] rdData;
  logic        sclk, mosi;
  wire         miso;
  logic [2:0]  chipSel;
  int checks = 0, errors = 0;
  bit finished = 0;

  bspiMaster dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .sclk(sclk), .mosi(mosi),
    .miso(miso), .chipSel(chipSel));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural mode-0 slave: drives on falling sclk, captures on rising.
  logic [7:0] slvByte = 0, slvSh = 0, slvRx = 0;
  logic       slvLd = 0;
  always @(negedge sclk or posedge slvLd)
    if (slvLd) slvSh <= slvByte; else slvSh <= {slvSh[6:0], 1'b0};
  always @(posedge sclk) slvRx <= {slvRx[6:0], mosi};
  assign miso = slvSh[7];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ctlWord(int d, bit lp, logic [2:0] cs, bit st);
    return {d[4:0], 22'b0, cs[2], lp, cs[1], st, cs[0]};
  endfunction

  task automatic busWrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0; addr = 0;
  endtask

  // One exchange, compared against the reference model every cycle.
  task automatic xfer(logic [7:0] tx, logic [7:0] sb, int d, bit lp,
                      logic [2:0] cs, bit inj);
    int total = 16 * (d + 1);
    slvByte = sb; slvLd = 1; #1 slvLd = 0;
    busWrite(4'h4, {24'h0, tx});
    wrEn = 1; addr = 0; wrData = ctlWord(d, lp, cs, 1'b1);
    @(negedge clk); wrEn = 0;
    check("R3", "chipSel after write", {29'b0, chipSel}, {29'b0, cs});
    for (int e = 0; e <= total + 1; e++) begin
      int h = e / (d + 1);
      bit expBusy = e < total;
      if (addr == 0) check("R2", "busy flag", {31'b0, rdData[1]}, {31'b0, expBusy});
      check("R4", "sclk level", {31'b0, sclk}, {31'b0, expBusy && h[0]});
      if (expBusy) check("R5", "mosi bit", {31'b0, mosi}, {31'b0, tx[7 - h/2]});
      wrEn = 0; addr = 0;
      if (inj && e == 3) begin wrEn = 1; addr = 0; wrData = ctlWord(d, lp, cs, 1'b1); end
      if (inj && e == 4) begin wrEn = 1; addr = 4; wrData = 32'h0000_00FF ^ {24'h0, tx}; end
      @(negedge clk);
    end
    wrEn = 0; addr = 4; #1;
    check(lp ? "R6" : "R7", "received byte", rdData, {24'h0, lp ? tx : sb});
    check("R5", "slave captured", {24'h0, slvRx}, {24'h0, tx});
    addr = 0; #1;
    check("R9", "control readback", rdData, ctlWord(d, lp, cs, 1'b0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; #1;
    addr = 0; #1;
    check("R1", "reset control word", rdData, 32'h0000_0015);
    addr = 4; #1;
    check("R1", "reset data word", rdData, 32'h0);
    check("R1", "reset selects", {29'b0, chipSel}, 32'h7);
    check("R4", "reset sclk", {31'b0, sclk}, 32'h0);
    addr = 0;

    xfer(8'hA5, 8'h3C, 0, 1'b0, 3'b110, 1'b0);
    xfer(8'h81, 8'h7E, 3, 1'b0, 3'b101, 1'b0);
    xfer(8'hC3, 8'hFF, 1, 1'b1, 3'b011, 1'b0);   // R6 loopback, miso ignored
    xfer(8'h5A, 8'h96, 2, 1'b0, 3'b110, 1'b0);   // back-to-back pair
    xfer(8'h0F, 8'hF0, 2, 1'b0, 3'b110, 1'b0);
    xfer(8'hE7, 8'h18, 1, 1'b0, 3'b111, 1'b1);   // R8 writes while busy

    busWrite(4'h0, 32'h07FF_FFF5);
    #1; check("R9", "unused bits read 0", rdData, 32'h0000_0015);
    check("R3", "all selects high", {29'b0, chipSel}, 32'h7);
    busWrite(4'h0, 32'hF800_0008);
    #1; check("R9", "divider and loop readback", rdData, 32'hF800_0008);
    check("R3", "all selects low", {29'b0, chipSel}, 32'h0);
    addr = 4; #1;
    check("R7", "data kept across control write", rdData, 32'h0000_0018);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule